// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder (16 bits)

This block is a purely combinational 16-bit binary adder. It takes two operands and a carry-in and returns a 16-bit sum and a carry-out. The operand width is split into four 4-bit slices. Each slice forms a per-bit carry-generate term and a per-bit carry-propagate term. From these it derives its own internal carries and one slice-level generate/propagate pair.

A separate second-level unit reads the four slice-level pairs and the external carry-in. It produces the carry into every slice and the final carry-out in one flat sum-of-products step. No carry passes from one slice to the next. This keeps the logic depth fixed and small, so the block suits address, branch-target and ALU datapaths that must close timing in a single cycle.

Top module: `cla16_adder`

## Requirements
- R1: For every input combination, the 17-bit value {carry_o, sum_o} equals op_a + op_b + carry_i, treating both operands as unsigned.
- R2: A carry-in of 1 with op_a = 16'hFFFF and op_b = 16'h0000 travels through all four slices: sum_o = 16'h0000 and carry_o = 1.
- R3: A carry created in slice k (bits 4k to 4k+3) appears as the carry into slice k+1. For example, 16'h000F + 16'h0001 gives 16'h0010, and 16'h0F00 + 16'h0100 gives 16'h1000.
- R4: The carry-out is the carry leaving the top slice. 16'h8000 + 16'h8000 gives sum_o = 16'h0000 and carry_o = 1.
- R5: When both operands are zero and carry_i = 0, sum_o = 0 and carry_o = 0.
- R6: Bit positions where both operand bits are 1 (generate and propagate both active) still add correctly. 16'hFFFF + 16'hFFFF + 1 gives carry_o = 1 and sum_o = 16'hFFFF.
- R7: Addition is commutative: swapping op_a and op_b leaves sum_o and carry_o unchanged.
- R8: When a slice propagates without generating, its carry-out equals its carry-in. When it generates, its carry-out is 1. The carry computed inside each slice always agrees with the carry the second-level unit delivers to the next slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| carry_o | output | 1 | Carry out of bit 15 |

## Verification
Some properties are checked on every evaluation by immediate assertions:
- the full 17-bit result against an arithmetic sum;
- each slice's own top carry against the carry the second-level unit computes;
- the slice-level propagate/generate consequences;
- the all-propagate and no-generate behaviour of the second level.

Other behaviours can only be shown by the bench's scenarios, which drive specific operand pairs:
- the carry travelling the full width;
- generation at each slice boundary;
- the top-bit carry-out;
- commutativity under operand swap.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int CLA_WIDTH  = 16;
  localparam int CLA_SLICE  = 4;
  localparam int CLA_NSLICE = CLA_WIDTH / CLA_SLICE;
endpackage

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
(
  input  logic [CLA_SLICE-1:0] a_i,
  input  logic [CLA_SLICE-1:0] b_i,
  input  logic                 cin_i,
  output logic [CLA_SLICE-1:0] sum_o,
  output logic                 sgen_o,
  output logic                 sprop_o,
  output logic                 cout_o
);
  logic [CLA_SLICE-1:0] gen;
  logic [CLA_SLICE-1:0] prop;
  logic [CLA_SLICE:0]   cy;

  // step 1: per-bit terms
  always_comb begin
    gen  = a_i & b_i;
    prop = a_i | b_i;
  end

  // step 2: slice-level terms
  always_comb begin
    sprop_o = &prop;
    sgen_o  = gen[3]
            | (prop[3] & gen[2])
            | (prop[3] & prop[2] & gen[1])
            | (prop[3] & prop[2] & prop[1] & gen[0]);
  end

  // step 4: internal carries from the delivered carry-in
  always_comb begin
    cy[0] = cin_i;
    cy[1] = gen[0] | (prop[0] & cin_i);
    cy[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & cin_i);
    cy[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
          | (prop[2] & prop[1] & prop[0] & cin_i);
    cy[4] = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
          | (prop[3] & prop[2] & prop[1] & gen[0])
          | (prop[3] & prop[2] & prop[1] & prop[0] & cin_i);
  end

  // step 5: sum bits
  always_comb begin
    sum_o  = a_i ^ b_i ^ cy[CLA_SLICE-1:0];
    cout_o = cy[CLA_SLICE];
  end

  always_comb begin
    if (sgen_o)
      p_slice_gen_r8: assert (cout_o == 1'b1);
    if (sprop_o && !sgen_o)
      p_slice_prop_r8: assert (cout_o == cin_i);
    p_slice_sum_r1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {4'd0, cin_i}));
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
(
  input  logic [CLA_NSLICE-1:0] sgen_i,
  input  logic [CLA_NSLICE-1:0] sprop_i,
  input  logic                  cin_i,
  output logic [CLA_NSLICE:0]   carry_o
);
  logic [CLA_NSLICE-1:0] G;
  logic [CLA_NSLICE-1:0] P;

  always_comb begin
    G = sgen_i;
    P = sprop_i;
  end

  // step 3: slice carries, all flat two-level expressions
  always_comb begin
    carry_o[0] = cin_i;
    carry_o[1] = G[0] | (P[0] & cin_i);
    carry_o[2] = G[1] | (P[1] & G[0]) | (P[1] & P[0] & cin_i);
    carry_o[3] = G[2] | (P[2] & G[1]) | (P[2] & P[1] & G[0])
               | (P[2] & P[1] & P[0] & cin_i);
    carry_o[4] = G[3] | (P[3] & G[2]) | (P[3] & P[2] & G[1])
               | (P[3] & P[2] & P[1] & G[0])
               | (P[3] & P[2] & P[1] & P[0] & cin_i);
  end

  always_comb begin
    if ((&P) && cin_i)
      p_full_chain_r2: assert (carry_o[CLA_NSLICE] == 1'b1);
    if ((G == '0) && !cin_i)
      p_no_carry_r5: assert (carry_o == '0);
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
(
  input  logic [CLA_WIDTH-1:0] op_a,
  input  logic [CLA_WIDTH-1:0] op_b,
  input  logic                 carry_i,
  output logic [CLA_WIDTH-1:0] sum_o,
  output logic                 carry_o
);
  logic [CLA_NSLICE-1:0] sgen;
  logic [CLA_NSLICE-1:0] sprop;
  logic [CLA_NSLICE-1:0] slice_cout;
  logic [CLA_NSLICE:0]   slice_cin;

  cla_lookahead u_lookahead (
    .sgen_i  (sgen),
    .sprop_i (sprop),
    .cin_i   (carry_i),
    .carry_o (slice_cin)
  );

  for (genvar k = 0; k < CLA_NSLICE; k++) begin : g_slice
    cla_slice u_slice (
      .a_i     (op_a[k*CLA_SLICE +: CLA_SLICE]),
      .b_i     (op_b[k*CLA_SLICE +: CLA_SLICE]),
      .cin_i   (slice_cin[k]),
      .sum_o   (sum_o[k*CLA_SLICE +: CLA_SLICE]),
      .sgen_o  (sgen[k]),
      .sprop_o (sprop[k]),
      .cout_o  (slice_cout[k])
    );
  end

  assign carry_o = slice_cin[CLA_NSLICE];

  always_comb begin
    p_sum_exact_r1: assert ({carry_o, sum_o} ==
                            ({1'b0, op_a} + {1'b0, op_b} + {{CLA_WIDTH{1'b0}}, carry_i}));
    p_no_ripple_r8: assert (slice_cout == slice_cin[CLA_NSLICE:1]);
  end
endmodule

// File: tb/sim_cla16_adder.sv
module sim_cla16_adder;
  logic        clk;
  logic [15:0] op_a, op_b;
  logic        carry_i;
  logic [15:0] sum_o;
  logic        carry_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cla16_adder u0 (.op_a(op_a), .op_b(op_b), .carry_i(carry_i),
                  .sum_o(sum_o), .carry_o(carry_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic apply_check(input logic [15:0] a, input logic [15:0] b,
                             input logic ci, input string req);
    logic [16:0] exp;
    @(posedge clk);
    op_a = a; op_b = b; carry_i = ci;
    exp = {1'b0, a} + {1'b0, b} + {16'd0, ci};
    @(negedge clk);
    checks++;
    if ({carry_o, sum_o} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h",
               req, a, b, ci, {carry_o, sum_o}, exp);
    end
  endtask

  task automatic t_zero_r5();
    apply_check(16'h0000, 16'h0000, 1'b0, "R5");
  endtask

  task automatic t_full_chain_r2();
    apply_check(16'hFFFF, 16'h0000, 1'b1, "R2");
    apply_check(16'h0000, 16'hFFFF, 1'b1, "R2");
    apply_check(16'hFFFE, 16'h0001, 1'b1, "R2");
  endtask

  task automatic t_slice_gen_r3();
    apply_check(16'h000F, 16'h0001, 1'b0, "R3");
    apply_check(16'h00F0, 16'h0010, 1'b0, "R3");
    apply_check(16'h0F00, 16'h0100, 1'b0, "R3");
    apply_check(16'h0008, 16'h0008, 1'b0, "R3");
  endtask

  task automatic t_top_carry_r4();
    apply_check(16'h8000, 16'h8000, 1'b0, "R4");
    apply_check(16'hF000, 16'h1000, 1'b0, "R4");
  endtask

  task automatic t_both_set_r6();
    apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    apply_check(16'hFFFF, 16'hFFFF, 1'b0, "R6");
    apply_check(16'hAAAA, 16'hAAAA, 1'b1, "R6");
  endtask

  task automatic t_slice_prop_r8();
    apply_check(16'h0FFF, 16'h0000, 1'b1, "R8");
    apply_check(16'h00F0, 16'h000F, 1'b1, "R8");
    apply_check(16'h5555, 16'hAAAA, 1'b0, "R8");
    apply_check(16'h5555, 16'hAAAA, 1'b1, "R8");
  endtask

  task automatic t_corners_r1();
    logic [15:0] pats [8];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8000; pats[3] = 16'h7FFF;
    pats[4] = 16'h000F; pats[5] = 16'hF0F0; pats[6] = 16'h0001; pats[7] = 16'h1234;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int c = 0; c < 2; c++)
          apply_check(pats[i], pats[j], c[0], "R1");
  endtask

  task automatic t_random_r1();
    for (int n = 0; n < 400; n++)
      apply_check(16'($urandom), 16'($urandom), 1'($urandom), "R1");
  endtask

  task automatic t_commute_r7();
    logic [16:0] first;
    for (int n = 0; n < 20; n++) begin
      logic [15:0] a, b;
      logic ci;
      a = 16'($urandom); b = 16'($urandom); ci = 1'($urandom);
      apply_check(a, b, ci, "R7");
      first = {carry_o, sum_o};
      apply_check(b, a, ci, "R7");
      checks++;
      if ({carry_o, sum_o} !== first) begin
        errors++;
        $display("FAIL R7: swapped actual=%h expected=%h", {carry_o, sum_o}, first);
      end
    end
  endtask

  initial begin
    op_a = '0; op_b = '0; carry_i = 1'b0;
    t_zero_r5();
    t_full_chain_r2();
    t_slice_gen_r3();
    t_top_carry_r4();
    t_both_set_r6();
    t_slice_prop_r8();
    t_corners_r1();
    t_random_r1();
    t_commute_r7();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule